// File: doc/BRIEF.md
# Debug Arm and Immediate-Trigger Control Register

This block is the single control byte of an on-chip debug unit. Software writes it over a plain register bus to arm the debug state sequencer, pick which comparator bank is visible, set four configuration bits, and ask for an immediate trigger. Reads return the stored state at once, through combinational logic.

Arming changes which bits can be written. While the unit is armed, only the arm bit, the trigger bit and the bank select can change. The four configuration bits stay frozen until the unit is disarmed. A hardware disarm pulse from the surrounding debug logic clears the arm bit, and it wins over any software write in the same cycle.

The trigger bit is write-only. A write of 1 makes a one-cycle trigger pulse unless secure mode is on or tracing is already running with begin or mid alignment. A rising arm bit makes a one-cycle pulse that moves the sequencer into its first state.

Top module: `dbg_arm_ctrl`

## Requirements
- R1: After reset the read data is 0x00, and the arm, trigger-pulse and enter-state-1 outputs are 0.
- R2: A write updates the arm bit (bit 7) and the bank select (bits 1:0) whatever the current arm state. The new values are visible on read data from the clock edge that takes the write.
- R3: A write updates the configuration bits (bits 5:2) only if the unit was disarmed before that write. While the unit is armed, those bits keep their value.
- R4: A write that clears the arm bit while the unit is armed leaves bits 5:2 unchanged. A later write made while disarmed can change them.
- R5: Bit 6 of read data is always 0.
- R6: A write with bit 6 set, made with secure mode off and no begin/mid-aligned tracing in progress, drives the trigger pulse high for exactly the one cycle after the write edge. A write with bit 6 clear makes no pulse.
- R7: While secure mode is high, a write with bit 6 set makes no trigger pulse.
- R8: While tracing is active and the begin/mid alignment flag is high, a write with bit 6 set makes no trigger pulse. Either flag alone does not block the pulse.
- R9: The enter-state-1 output is high for exactly one cycle, the first cycle in which the arm bit is 1 after being 0. It stays low for a write that keeps the arm bit at 1.
- R10: A hardware disarm pulse clears the arm bit at the next edge, even when a write setting bit 7 lands in the same cycle. The other fields of that write still follow R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: {arm, 0, cfg[3:0], sel[1:0]} |
| secure_i | input | 1 | Secure mode, blocks trigger requests |
| hw_disarm_i | input | 1 | Hardware disarm pulse (session done or breakpoint without tracing) |
| trace_active_i | input | 1 | Tracing is in progress |
| align_bm_i | input | 1 | Trace alignment is begin or mid |
| arm_o | output | 1 | Arm level |
| trig_pulse_o | output | 1 | One-cycle immediate-trigger request |
| enter_s1_o | output | 1 | One-cycle sequencer enter-state-1 pulse |
| cfg_o | output | 4 | Stored configuration bits |
| sel_o | output | 2 | Stored comparator-bank select |

## Verification
The bench drives every one of the 256 write values under each of the 16 combinations of secure mode, tracing, alignment and hardware disarm. Because the values run in order, writes land both while armed and while disarmed. This tells apart masking that depends on the stored arm state from masking that depends on the written arm bit. The writes that go from 0xFF to 0x00 are disarming writes that must not touch the configuration bits. The tracing/alignment combinations separate the correct AND gate from an OR gate or from a single flag. The hardware-disarm cases show that the disarm wins and that the other fields are still written. A separate disarm pulse with no write, and a check that each pulse falls after one cycle, complete the sweep.

// File: rtl/dbg_arm_pkg.sv
// Package: shared widths and field positions for the debug arm/trigger
// control register. Assumes the byte is laid out as {arm, trig, cfg, sel}.
package dbg_arm_pkg;
    parameter int unsigned CFG_W_DEF = 4;
    parameter int unsigned SEL_W_DEF = 2;

    // Total register width for a given field configuration.
    function automatic int unsigned reg_width(input int unsigned cfg_w, input int unsigned sel_w);
        return 2 + cfg_w + sel_w;
    endfunction
endpackage

// File: rtl/dbg_arm_wdec.sv
// Module: splits a register write into per-field values and write enables.
// Assumes arm_q is the stored arm level before the write. The configuration
// field is enabled only while that level is 0.
module dbg_arm_wdec #(
    parameter int unsigned CFG_W = dbg_arm_pkg::CFG_W_DEF,
    parameter int unsigned SEL_W = dbg_arm_pkg::SEL_W_DEF,
    localparam int unsigned DW   = dbg_arm_pkg::reg_width(CFG_W, SEL_W)
) (
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             arm_q_i,
    output logic             arm_we_o,
    output logic             arm_val_o,
    output logic             trig_req_o,
    output logic             cfg_we_o,
    output logic [CFG_W-1:0] cfg_val_o,
    output logic             sel_we_o,
    output logic [SEL_W-1:0] sel_val_o
);
    localparam int unsigned ARM_POS = DW - 1;
    localparam int unsigned TRG_POS = DW - 2;
    localparam int unsigned CFG_LO  = SEL_W;

    // Field split and arm-dependent write masking.
    always_comb begin
        arm_we_o   = wr_i;
        arm_val_o  = wdata_i[ARM_POS];
        trig_req_o = wr_i & wdata_i[TRG_POS];
        cfg_we_o   = wr_i & ~arm_q_i;
        cfg_val_o  = wdata_i[CFG_LO +: CFG_W];
        sel_we_o   = wr_i;
        sel_val_o  = wdata_i[SEL_W-1:0];
    end
endmodule

// File: rtl/dbg_arm_state.sv
// Module: stored arm, configuration and select state, plus the pulse that
// starts the sequencer. Assumes a hardware disarm takes priority over a
// software write in the same cycle.
module dbg_arm_state #(
    parameter int unsigned CFG_W = dbg_arm_pkg::CFG_W_DEF,
    parameter int unsigned SEL_W = dbg_arm_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_disarm_i,
    input  logic             arm_we_i,
    input  logic             arm_val_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_val_i,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_val_i,
    output logic             arm_q_o,
    output logic [CFG_W-1:0] cfg_q_o,
    output logic [SEL_W-1:0] sel_q_o,
    output logic             enter_s1_o
);
    logic arm_nxt;

    // Next arm level: hardware disarm first, then software write, else hold.
    always_comb begin
        if (hw_disarm_i)   arm_nxt = 1'b0;
        else if (arm_we_i) arm_nxt = arm_val_i;
        else               arm_nxt = arm_q_o;
    end

    // Arm level and its rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q_o    <= 1'b0;
            enter_s1_o <= 1'b0;
        end else begin
            arm_q_o    <= arm_nxt;
            enter_s1_o <= arm_nxt & ~arm_q_o;
        end
    end

    // Configuration field, written only through the masked enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q_o <= '0;
        else if (cfg_we_i) cfg_q_o <= cfg_val_i;
    end

    // Bank select, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q_o <= '0;
        else if (sel_we_i) sel_q_o <= sel_val_i;
    end

    assert_cfg_frozen_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q_o |=> $stable(cfg_q_o));

    assert_enter_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enter_s1_o |-> (arm_q_o && !$past(arm_q_o)));

    assert_hw_disarm_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_disarm_i |=> !arm_q_o);
endmodule

// File: rtl/dbg_arm_trig.sv
// Module: gates a software trigger request and registers it into a
// one-cycle pulse. Assumes the tracing and alignment flags are level
// signals, valid in the cycle of the write.
module dbg_arm_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic trig_req_i,
    input  logic secure_i,
    input  logic trace_active_i,
    input  logic align_bm_i,
    output logic trig_pulse_o
);
    logic blocked;

    // A request is dropped in secure mode or once begin/mid tracing has started.
    always_comb blocked = secure_i | (trace_active_i & align_bm_i);

    // Register the gated request as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_pulse_o <= 1'b0;
        else        trig_pulse_o <= trig_req_i & ~blocked;
    end

    assert_pulse_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse_o |-> $past(trig_req_i && wr_i));

    assert_secure_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && secure_i) |=> !trig_pulse_o);

    assert_trace_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && trace_active_i && align_bm_i) |=> !trig_pulse_o);
endmodule

// File: rtl/dbg_arm_ctrl.sv
// Module: top of the debug arm/trigger control register. Connects the
// write decoder, state and trigger gate, and packs the read data.
// Assumes a single register, so there is no address decode.
module dbg_arm_ctrl #(
    parameter int unsigned CFG_W = dbg_arm_pkg::CFG_W_DEF,
    parameter int unsigned SEL_W = dbg_arm_pkg::SEL_W_DEF,
    localparam int unsigned DW   = dbg_arm_pkg::reg_width(CFG_W, SEL_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             secure_i,
    input  logic             hw_disarm_i,
    input  logic             trace_active_i,
    input  logic             align_bm_i,
    output logic             arm_o,
    output logic             trig_pulse_o,
    output logic             enter_s1_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [SEL_W-1:0] sel_o
);
    logic             arm_we, arm_val, trig_req, cfg_we, sel_we;
    logic [CFG_W-1:0] cfg_val;
    logic [SEL_W-1:0] sel_val;

    dbg_arm_wdec #(.CFG_W(CFG_W), .SEL_W(SEL_W)) u_wdec (
        .wr_i       (reg_wr),
        .wdata_i    (reg_wdata),
        .arm_q_i    (arm_o),
        .arm_we_o   (arm_we),
        .arm_val_o  (arm_val),
        .trig_req_o (trig_req),
        .cfg_we_o   (cfg_we),
        .cfg_val_o  (cfg_val),
        .sel_we_o   (sel_we),
        .sel_val_o  (sel_val)
    );

    dbg_arm_state #(.CFG_W(CFG_W), .SEL_W(SEL_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_disarm_i (hw_disarm_i),
        .arm_we_i    (arm_we),
        .arm_val_i   (arm_val),
        .cfg_we_i    (cfg_we),
        .cfg_val_i   (cfg_val),
        .sel_we_i    (sel_we),
        .sel_val_i   (sel_val),
        .arm_q_o     (arm_o),
        .cfg_q_o     (cfg_o),
        .sel_q_o     (sel_o),
        .enter_s1_o  (enter_s1_o)
    );

    dbg_arm_trig u_trig (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_i           (reg_wr),
        .trig_req_i     (trig_req),
        .secure_i       (secure_i),
        .trace_active_i (trace_active_i),
        .align_bm_i     (align_bm_i),
        .trig_pulse_o   (trig_pulse_o)
    );

    // Read data: the trigger position always returns 0.
    always_comb reg_rdata = {arm_o, 1'b0, cfg_o, sel_o};

    assert_rd_arm_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !hw_disarm_i) |=> (reg_rdata[DW-1] == $past(reg_wdata[DW-1])));
endmodule

// File: tb/dbg_arm_ctrl_bench.sv
// Bench: sweeps all write values under every combination of the side
// inputs and checks against a model derived from the requirements.
module dbg_arm_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       secure_i = 1'b0, hw_disarm_i = 1'b0, trace_active_i = 1'b0, align_bm_i = 1'b0;
    logic       arm_o, trig_pulse_o, enter_s1_o;
    logic [3:0] cfg_o;
    logic [1:0] sel_o;

    int n_chk = 0;
    int n_bad = 0;

    logic       m_arm = 1'b0;
    logic [3:0] m_cfg = 4'h0;
    logic [1:0] m_sel = 2'h0;

    always #10 clk = ~clk;

    dbg_arm_ctrl u_dbg_arm_ctrl (
        .clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata,
        .secure_i, .hw_disarm_i, .trace_active_i, .align_bm_i,
        .arm_o, .trig_pulse_o, .enter_s1_o, .cfg_o, .sel_o
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // One write with side inputs; checks the cycle after and the pulse fall.
    task automatic do_write(input logic [7:0] v, input logic [3:0] c);
        logic n_arm, e_trig, e_ent, blk;
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        secure_i = c[0]; trace_active_i = c[1]; align_bm_i = c[2]; hw_disarm_i = c[3];
        n_arm  = c[3] ? 1'b0 : v[7];
        blk    = c[0] | (c[1] & c[2]);
        e_trig = v[6] & ~blk;
        e_ent  = ~m_arm & n_arm;
        if (!m_arm) m_cfg = v[5:2];
        m_sel = v[1:0];
        @(negedge clk);
        reg_wr = 1'b0; hw_disarm_i = 1'b0;
        chk(c[3] ? "R10 arm" : "R2 arm", {7'b0, reg_rdata[7]}, {7'b0, n_arm});
        chk("R2 sel", {6'b0, reg_rdata[1:0]}, {6'b0, m_sel});
        chk((m_arm && !n_arm) ? "R4 cfg" : "R3 cfg", {4'b0, reg_rdata[5:2]}, {4'b0, m_cfg});
        chk("R5 bit6", {7'b0, reg_rdata[6]}, 8'h00);
        chk(c[0] ? "R7 trig" : ((c[1] || c[2]) ? "R8 trig" : "R6 trig"), {7'b0, trig_pulse_o}, {7'b0, e_trig});
        chk("R9 enter", {7'b0, enter_s1_o}, {7'b0, e_ent});
        m_arm = n_arm;
        @(negedge clk);
        chk("R6 pulse one cycle", {7'b0, trig_pulse_o}, 8'h00);
        chk("R9 pulse one cycle", {7'b0, enter_s1_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 outs", {5'b0, arm_o, trig_pulse_o, enter_s1_o}, 8'h00);
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 256; v++) do_write(v[7:0], c[3:0]);
        end
        // Arm with known config, then a lone hardware disarm.
        do_write(8'h00, 4'h0);
        do_write(8'hA9, 4'h0);
        @(negedge clk); hw_disarm_i = 1'b1;
        @(negedge clk); hw_disarm_i = 1'b0;
        chk("R10 lone disarm", reg_rdata, 8'h29);
        chk("R9 no pulse on disarm", {7'b0, enter_s1_o}, 8'h00);
        m_arm = 1'b0;
        // Re-write while armed keeps the enter pulse low.
        do_write(8'h80, 4'h0);
        do_write(8'h81, 4'h0);
        summary();
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end
endmodule